// File: doc/BRIEF.md
# Subroutine Call Stack Pusher

This block carries out the stack half of an absolute subroutine call on an 8-bit processor with a 16-bit address space. The call opcode is 0xCD, followed by two operand bytes. The fetch logic assembles those bytes and hands them to the block with a one-cycle start pulse. It also supplies the address of the opcode and the current stack pointer.

The block then steps through the five machine cycles of the call, one clock per T-state. The lengths are 4, 3, 4, 3 and 3, for 17 T-states in total. The first three machine cycles only account for time, because opcode and operand fetch happen elsewhere. The stack pointer drops by one at the end of the third machine cycle and again at the end of the fourth. The last T-state of the fourth and fifth machine cycles each carry one byte write on a byte-wide memory port. The return address is the opcode address plus three, and its high byte goes out first.

After the second write the block loads the program counter with the target and raises a one-clock done pulse. At the same time it presents the final stack pointer and the T-state count. The block does not touch any condition flag.

Top module: `callpush_top`

## Requirements
- R1: After reset `busy_o`, `done_o` and `mem_we_o` are 0, and `pc_o`, `sp_o` and `cycles_o` are 0.
- R2: The pushed return address is the opcode address `pc_i` plus 3, modulo 2^16, so 0xFFFE pushes 0x0001.
- R3: The first write puts bits 15:8 of the return address at SP-1. The second write puts bits 7:0 at SP-2.
- R4: Stack pointer decrements wrap from 0x0000 to 0xFFFF.
- R5: Each call makes exactly two writes. The write strobe stays high for a single clock each time, with address and data valid in that clock.
- R6: Counting the clock edge that samples `start_i` as edge 0, the strobe is high in the clock after edges 13 and 16. These are the last T-states of machine cycles 4 and 5.
- R7: `done_o` is high for one clock only, the clock after edge 17. In that clock `pc_o` equals {second operand byte, first operand byte}, `sp_o` equals SP-2 and `cycles_o` equals 17.
- R8: A start pulse while `busy_o` is high, including the done clock, is ignored. Neither the writes nor the results change.
- R9: Once the block is idle, `pc_o`, `sp_o` and `cycles_o` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a call (sampled when idle) |
| pc_i | input | 16 | Address of the call opcode |
| sp_i | input | 16 | Stack pointer before the call |
| tgt_lo_i | input | 8 | First operand byte (target bits 7:0) |
| tgt_hi_i | input | 8 | Second operand byte (target bits 15:8) |
| busy_o | output | 1 | Call in progress, including the done clock |
| done_o | output | 1 | One-clock completion pulse |
| mem_addr_o | output | 16 | Memory write address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| pc_o | output | 16 | Program counter after the call |
| sp_o | output | 16 | Stack pointer |
| cycles_o | output | 5 | T-states spent by the last call |

## Verification
The bench aims at the edges of 16-bit arithmetic. An opcode address of 0xFFFE must push 0x0001; a design that forgets the carry into the high byte pushes 0xFF01. Stack pointers of 0x0000 and 0x0001 must wrap the writes to 0xFFFF and 0x0000; a design that saturates or skips the pre-decrement writes over the caller's data. The write order and exact clocks are checked, so swapped bytes or an off-by-one machine-cycle length show up as data or timing mismatches. A second start is issued mid-call and again during the done clock. A design that re-arms would push the second set of values or produce a third write.

// File: rtl/callpush_pkg.sv
`timescale 1ns/1ps
package callpush_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_FETCH = 3'd1,
        PH_RDLO  = 3'd2,
        PH_RDHI  = 3'd3,
        PH_WRHI  = 3'd4,
        PH_WRLO  = 3'd5,
        PH_DONE  = 3'd6
    } phase_e;

    function automatic phase_e next_phase(input phase_e cur);
        case (cur)
            PH_FETCH: next_phase = PH_RDLO;
            PH_RDLO:  next_phase = PH_RDHI;
            PH_RDHI:  next_phase = PH_WRHI;
            PH_WRHI:  next_phase = PH_WRLO;
            PH_WRLO:  next_phase = PH_DONE;
            default:  next_phase = PH_IDLE;
        endcase
    endfunction

    function automatic logic is_running(input phase_e cur);
        is_running = (cur == PH_FETCH) || (cur == PH_RDLO) || (cur == PH_RDHI) ||
                     (cur == PH_WRHI)  || (cur == PH_WRLO);
    endfunction

endpackage

// File: rtl/callpush_seq.sv
`timescale 1ns/1ps
module callpush_seq
    import callpush_pkg::*;
#(
    parameter int unsigned T_FETCH = 4,
    parameter int unsigned T_RDLO  = 3,
    parameter int unsigned T_RDHI  = 4,
    parameter int unsigned T_WR    = 3,
    parameter int unsigned CYC_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             accept_o,
    output phase_e           phase_o,
    output logic             last_t_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [CYC_W-1:0] cycles_o
);

    typedef struct packed {
        phase_e           phase;
        logic [CYC_W-1:0] tcnt;
        logic [CYC_W-1:0] tsum;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic [CYC_W-1:0] len;
    logic             run;
    logic             last_t;

    always_comb begin
        case (seq_q.phase)
            PH_FETCH: len = CYC_W'(T_FETCH);
            PH_RDLO:  len = CYC_W'(T_RDLO);
            PH_RDHI:  len = CYC_W'(T_RDHI);
            PH_WRHI,
            PH_WRLO:  len = CYC_W'(T_WR);
            default:  len = CYC_W'(1);
        endcase
        run    = is_running(seq_q.phase);
        last_t = run && (seq_q.tcnt == len - CYC_W'(1));
    end

    always_comb begin
        seq_d    = seq_q;
        accept_o = 1'b0;
        case (seq_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    accept_o    = 1'b1;
                    seq_d.phase = PH_FETCH;
                    seq_d.tcnt  = '0;
                    seq_d.tsum  = '0;
                end
            end
            PH_DONE: seq_d.phase = PH_IDLE;
            default: begin
                seq_d.tsum = seq_q.tsum + CYC_W'(1);
                if (last_t) begin
                    seq_d.phase = next_phase(seq_q.phase);
                    seq_d.tcnt  = '0;
                end else begin
                    seq_d.tcnt  = seq_q.tcnt + CYC_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.phase <= PH_IDLE;
            seq_q.tcnt  <= '0;
            seq_q.tsum  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_o  = seq_q.phase;
    assign last_t_o = last_t;
    assign busy_o   = (seq_q.phase != PH_IDLE);
    assign done_o   = (seq_q.phase == PH_DONE);
    assign cycles_o = seq_q.tsum;

endmodule

// File: rtl/callpush_dp.sv
`timescale 1ns/1ps
module callpush_dp
    import callpush_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned INSN_LEN = 3,
    localparam int unsigned ADDR_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  phase_e            phase_i,
    input  logic              last_t_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [DATA_W-1:0] tgt_lo_i,
    input  logic [DATA_W-1:0] tgt_hi_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] sp_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] ret;
        logic [ADDR_W-1:0] tgt;
        logic [ADDR_W-1:0] sp;
        logic [ADDR_W-1:0] pc;
    } dp_t;

    dp_t  dp_d, dp_q;
    logic dec_sp;
    logic wr_slot;

    always_comb begin
        dec_sp  = last_t_i && ((phase_i == PH_RDHI) || (phase_i == PH_WRHI));
        wr_slot = last_t_i && ((phase_i == PH_WRHI) || (phase_i == PH_WRLO));
    end

    always_comb begin
        dp_d = dp_q;
        if (accept_i) begin
            dp_d.ret = pc_i + ADDR_W'(INSN_LEN);
            dp_d.tgt = {tgt_hi_i, tgt_lo_i};
            dp_d.sp  = sp_i;
        end
        if (dec_sp) begin
            dp_d.sp = dp_q.sp - ADDR_W'(1);
        end
        if (last_t_i && (phase_i == PH_WRLO)) begin
            dp_d.pc = dp_q.tgt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign mem_we_o    = wr_slot;
    assign mem_addr_o  = dp_q.sp;
    assign mem_wdata_o = (phase_i == PH_WRHI) ? dp_q.ret[ADDR_W-1 -: DATA_W]
                                              : dp_q.ret[DATA_W-1:0];
    assign pc_o        = dp_q.pc;
    assign sp_o        = dp_q.sp;

endmodule

// File: rtl/callpush_top.sv
`timescale 1ns/1ps
module callpush_top
    import callpush_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned INSN_LEN = 3,
    parameter int unsigned T_FETCH  = 4,
    parameter int unsigned T_RDLO   = 3,
    parameter int unsigned T_RDHI   = 4,
    parameter int unsigned T_WR     = 3,
    localparam int unsigned ADDR_W  = 2 * DATA_W,
    localparam int unsigned T_TOTAL = T_FETCH + T_RDLO + T_RDHI + 2 * T_WR,
    localparam int unsigned CYC_W   = $clog2(T_TOTAL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [DATA_W-1:0] tgt_lo_i,
    input  logic [DATA_W-1:0] tgt_hi_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic [CYC_W-1:0]  cycles_o
);

    logic   accept;
    phase_e phase;
    logic   last_t;

    callpush_seq #(
        .T_FETCH (T_FETCH),
        .T_RDLO  (T_RDLO),
        .T_RDHI  (T_RDHI),
        .T_WR    (T_WR),
        .CYC_W   (CYC_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .phase_o  (phase),
        .last_t_o (last_t),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .cycles_o (cycles_o)
    );

    callpush_dp #(
        .DATA_W   (DATA_W),
        .INSN_LEN (INSN_LEN)
    ) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .phase_i     (phase),
        .last_t_i    (last_t),
        .pc_i        (pc_i),
        .sp_i        (sp_i),
        .tgt_lo_i    (tgt_lo_i),
        .tgt_hi_i    (tgt_hi_i),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_we_o    (mem_we_o),
        .pc_o        (pc_o),
        .sp_o        (sp_o)
    );

endmodule

// File: rtl/callpush_chk.sv
`timescale 1ns/1ps
module callpush_chk #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned CYC_W   = 5,
    parameter int unsigned T_TOTAL = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] sp_o,
    input logic [CYC_W-1:0]  cycles_o
);

    logic [1:0]        wr_cnt_q;
    logic [ADDR_W-1:0] last_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt_q    <= '0;
            last_addr_q <= '0;
        end else begin
            if (!busy_o) begin
                wr_cnt_q <= '0;
            end else if (mem_we_o && wr_cnt_q != 2'd3) begin
                wr_cnt_q <= wr_cnt_q + 2'd1;
            end
            if (mem_we_o) begin
                last_addr_q <= mem_addr_o;
            end
        end
    end

    p_we_one_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o);

    p_we_inside_call_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (busy_o && !done_o));

    p_two_writes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (wr_cnt_q == 2'd2));

    p_low_below_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && wr_cnt_q == 2'd1) |-> (mem_addr_o == last_addr_q - ADDR_W'(1)));

    p_done_follows_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(mem_we_o));

    p_done_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cycles_o == CYC_W'(T_TOTAL)));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (sp_o == last_addr_q));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o)) |-> ($stable(pc_o) && $stable(sp_o) && $stable(cycles_o)));

endmodule

bind callpush_top callpush_chk #(
    .ADDR_W  (ADDR_W),
    .CYC_W   (CYC_W),
    .T_TOTAL (T_TOTAL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .pc_o       (pc_o),
    .sp_o       (sp_o),
    .cycles_o   (cycles_o)
);

// File: tb/tb_callpush_top.sv
`timescale 1ns/1ps
module tb_callpush_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] pc_i = '0;
    logic [15:0] sp_i = '0;
    logic [7:0]  tgt_lo_i = '0;
    logic [7:0]  tgt_hi_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic        mem_we_o;
    logic [15:0] pc_o;
    logic [15:0] sp_o;
    logic [4:0]  cycles_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    callpush_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pc_i        (pc_i),
        .sp_i        (sp_i),
        .tgt_lo_i    (tgt_lo_i),
        .tgt_hi_i    (tgt_hi_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_we_o    (mem_we_o),
        .pc_o        (pc_o),
        .sp_o        (sp_o),
        .cycles_o    (cycles_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One call; a second start with other values is driven at sample dup_at (0 = none).
    task automatic run_call(input logic [15:0] pc, input logic [15:0] sp,
                            input logic [7:0] lo, input logic [7:0] hi, input int dup_at);
        int          n_we = 0;
        int          n_done = 0;
        int          w_idx[2];
        logic [15:0] w_addr[2];
        logic [7:0]  w_data[2];
        int          done_idx = 0;
        logic [15:0] done_pc = '0;
        logic [15:0] done_sp = '0;
        logic [4:0]  done_cyc = '0;
        logic        busy_after = 1'b1;
        logic [15:0] ret = pc + 16'd3;
        logic [15:0] exp_a1 = sp - 16'd1;
        logic [15:0] exp_a2 = sp - 16'd2;
        @(negedge clk);
        start_i  = 1'b1;
        pc_i     = pc;
        sp_i     = sp;
        tgt_lo_i = lo;
        tgt_hi_i = hi;
        for (int i = 1; i <= 24; i++) begin
            @(negedge clk);
            if (mem_we_o) begin
                if (n_we < 2) begin
                    w_idx[n_we]  = i;
                    w_addr[n_we] = mem_addr_o;
                    w_data[n_we] = mem_wdata_o;
                end
                n_we++;
            end
            if (done_o) begin
                n_done++;
                done_idx = i;
                done_pc  = pc_o;
                done_sp  = sp_o;
                done_cyc = cycles_o;
            end
            if (i == 19) busy_after = busy_o;
            if (i == dup_at) begin
                start_i  = 1'b1;
                pc_i     = pc ^ 16'h5A5A;
                sp_i     = sp ^ 16'h0F0F;
                tgt_lo_i = ~lo;
                tgt_hi_i = ~hi;
            end else begin
                start_i  = 1'b0;
            end
        end
        check(n_we == 2, "R5", "write count", n_we, 2);
        if (n_we >= 2) begin
            check(w_addr[0] == exp_a1, "R3", "first write address", w_addr[0], exp_a1);
            check(w_data[0] == ret[15:8], "R2", "first write data (high byte)", w_data[0], ret[15:8]);
            check(w_addr[1] == exp_a2, "R4", "second write address", w_addr[1], exp_a2);
            check(w_data[1] == ret[7:0], "R3", "second write data (low byte)", w_data[1], ret[7:0]);
            check(w_idx[0] == 14, "R6", "first write clock", w_idx[0], 14);
            check(w_idx[1] == 17, "R6", "second write clock", w_idx[1], 17);
        end
        check(n_done == 1, "R7", "done pulses", n_done, 1);
        check(done_idx == 18, "R7", "done clock", done_idx, 18);
        check(done_pc == {hi, lo}, "R7", "pc after call", done_pc, {hi, lo});
        check(done_sp == exp_a2, "R7", "sp after call", done_sp, exp_a2);
        check(done_cyc == 5'd17, "R7", "T-state count", done_cyc, 17);
        check(busy_after == 1'b0, "R8", "idle after done", busy_after, 0);
    endtask

    task automatic t_reset();
        check(busy_o == 1'b0, "R1", "busy in reset", busy_o, 0);
        check(done_o == 1'b0, "R1", "done in reset", done_o, 0);
        check(mem_we_o == 1'b0, "R1", "strobe in reset", mem_we_o, 0);
        check(pc_o == 16'h0, "R1", "pc in reset", pc_o, 0);
        check(sp_o == 16'h0, "R1", "sp in reset", sp_o, 0);
        check(cycles_o == 5'd0, "R1", "count in reset", cycles_o, 0);
    endtask

    task automatic t_hold();
        logic [15:0] p = pc_o;
        logic [15:0] s = sp_o;
        logic [4:0]  c = cycles_o;
        int          we_seen = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (mem_we_o) we_seen++;
        end
        check(pc_o == p, "R9", "pc held", pc_o, p);
        check(sp_o == s, "R9", "sp held", sp_o, s);
        check(cycles_o == c, "R9", "count held", cycles_o, c);
        check(we_seen == 0, "R9", "no stray writes", we_seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_call(16'h1234, 16'h8000, 8'h78, 8'h56, 0);   // R2 R3 basic
        t_hold();                                        // R9
        run_call(16'hFFFE, 16'h4000, 8'hCD, 8'hAB, 0);   // R2 carry into high byte
        run_call(16'h0100, 16'h0000, 8'h01, 8'h02, 0);   // R4 wrap from zero
        run_call(16'h0200, 16'h0001, 8'hEF, 8'hBE, 0);   // R4 wrap on second write
        run_call(16'h3000, 16'hC000, 8'h11, 8'h22, 5);   // R8 start mid-call
        run_call(16'h4000, 16'hD000, 8'h33, 8'h44, 18);  // R8 start in done clock
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule